// File: doc/BRIEF.md
# PHY Management Serial Master

This block is a host-side master for the two-wire PHY management bus. It runs the 22-style frame, which carries a 5-bit PHY address, a 5-bit register address and 16 data bits. Software controls it through one 32-bit command word. Writing that word starts a serial frame at once. Reading the same word returns the busy flag, the read-complete flag, the echoed address fields and, after a read frame, the 16-bit result.

The management clock is made from the system clock by a divider whose half period is a parameter. Every frame has four parts:

- a preamble of 32 ones;
- the start pair `01`;
- an opcode, `10` for a read and `01` for a write;
- the PHY and register addresses, both sent MSB first.

On a write, the master then drives the turnaround pair `10` and 16 data bits. On a read, it releases the data line from the first turnaround bit to the end of the frame. It shifts in 16 bits on rising clock edges and reports them when the frame ends.

Software starts a command only after it sees busy clear. A command written while busy is set is dropped. A write needs no completion wait before software moves on.

Top module: `phy_mgmt_master`

## Requirements
- R1: The command word holds data in bits 15:0, the PHY address in 20:16, the register address in 25:21 and the operation in bit 26 (1 = read, 0 = write). An accepted command is echoed in those same bits on the next cycle. Bits 31:29 read 0.
- R2: Busy (bit 28) reads 1 from the cycle after an accepted command until the frame has ended, and then returns to 0.
- R3: A command written while busy is 1 changes none of the echoed fields, does not disturb the frame in progress, and starts no later frame.
- R4: Read-complete (bit 27) reads 0 from the cycle after any accepted command.
- R5: MDC has a period of 2×HALF_DIV system clocks, with HALF_DIV cycles high and HALF_DIV cycles low.
- R6: Every frame is 64 MDC bit times. It begins with 32 ones, then `01`, then opcode `10` (read) or `01` (write), then the PHY address and then the register address, each MSB first.
- R7: On a write frame, bits 46–47 are `10` and bits 48–63 are the data MSB first. The output enable stays high for all 64 bits.
- R8: On a read frame, the output enable is low for bits 46–63. Bits 48–63 are taken from the MDIO input on MDC rising edges, MSB first. When the frame ends, bit 27 reads 1 and bits 15:0 hold the received value.
- R9: The MDIO output changes only in the system clock cycle in which MDC falls.
- R10: After reset the command word reads 0 and MDC is low. The output enable is low whenever busy is 0.
- R11: A completed write frame leaves bit 27 at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Write strobe for the command word |
| cmd_wdata | input | 32 | Command word to write |
| cmd_rdata | output | 32 | Status, echoed fields and read result |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Serial data driven by the master |
| mdio_oe | output | 1 | Output enable for the data line |
| mdio_i | input | 1 | Serial data from the line |

## Verification
If the bit counter is off by one, the captured 64-bit frame is shifted, and this shows within the first frame after reset as a wrong address or opcode bit. A wrong release point or sample point in the read path shows up twice in the same frame: in the enable pattern, and in a 16-bit result that is shifted or inverted compared with the value the PHY model sent. A stuck or mis-timed flag is seen one cycle after the command strobe, or at the poll that follows the frame. An accepted command that was meant to be dropped shows as changed echo fields on the very next cycle.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;
  localparam int DATA_W    = 16;
  localparam int PHY_AW    = 5;
  localparam int REG_AW    = 5;
  localparam int PRE_LEN   = 32;
  localparam int FRAME_LEN = PRE_LEN + 2 + 2 + PHY_AW + REG_AW + 2 + DATA_W;
  localparam int CNT_W     = $clog2(FRAME_LEN + 1);
  // first bit index released on a read (first turnaround bit)
  localparam int REL_IDX   = FRAME_LEN - DATA_W - 2;
  // first data bit index
  localparam int DAT_IDX   = FRAME_LEN - DATA_W;
  // command word bit positions (software depends on these)
  localparam int PHY_LSB   = DATA_W;
  localparam int REG_LSB   = PHY_LSB + PHY_AW;
  localparam int OP_BIT    = REG_LSB + REG_AW;
  localparam int VALID_BIT = OP_BIT + 1;
  localparam int BUSY_BIT  = OP_BIT + 2;
  localparam int WORD_W    = 32;

  typedef enum logic {OP_WRITE = 1'b0, OP_READ = 1'b1} op_e;
endpackage

// File: rtl/mgmt_clk_div.sv
module mgmt_clk_div #(
  parameter int HALF_DIV = 20
) (
  input  logic clk,
  input  logic rst,
  output logic mdc,
  output logic fall_tick,
  output logic rise_tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] TERM = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          term;

  assign term      = (cnt_q == TERM);
  assign fall_tick = term &  mdc;
  assign rise_tick = term & ~mdc;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      mdc   <= 1'b0;
    end else if (term) begin
      cnt_q <= '0;
      mdc   <= ~mdc;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R5: level held between terminal counts
  a_r5_mdc_hold: assert property (@(posedge clk) disable iff (rst)
    !term |=> $stable(mdc));
endmodule

// File: rtl/mgmt_cmd_reg.sv
module mgmt_cmd_reg
  import phy_mgmt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [WORD_W-1:0]    wr_data,
  input  logic                 done,
  input  logic [DATA_W-1:0]    rx_data,
  output logic                 start,
  output logic                 start_rd,
  output logic [FRAME_LEN-1:0] start_frame,
  output logic                 busy,
  output logic [WORD_W-1:0]    status
);
  logic [DATA_W-1:0] data_q;
  logic [PHY_AW-1:0] phy_q;
  logic [REG_AW-1:0] reg_q;
  op_e               op_q;
  logic              busy_q, valid_q;

  logic [DATA_W-1:0] w_data;
  logic [PHY_AW-1:0] w_phy;
  logic [REG_AW-1:0] w_reg;
  logic              w_rd;
  logic [WORD_W-OP_BIT-2:0] unused_hi;

  assign w_data    = wr_data[DATA_W-1:0];
  assign w_phy     = wr_data[PHY_LSB +: PHY_AW];
  assign w_reg     = wr_data[REG_LSB +: REG_AW];
  assign w_rd      = wr_data[OP_BIT];
  assign unused_hi = wr_data[WORD_W-1:OP_BIT+1];

  assign start    = wr_en & ~busy_q;
  assign start_rd = w_rd;
  assign busy     = busy_q;

  always_comb begin
    start_frame = {{PRE_LEN{1'b1}}, 2'b01,
                   (w_rd ? 2'b10 : 2'b01),
                   w_phy, w_reg,
                   (w_rd ? 2'b11 : 2'b10),
                   (w_rd ? {DATA_W{1'b1}} : w_data)};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q  <= '0;
      phy_q   <= '0;
      reg_q   <= '0;
      op_q    <= OP_WRITE;
      busy_q  <= 1'b0;
      valid_q <= 1'b0;
    end else if (start) begin
      data_q  <= w_data;
      phy_q   <= w_phy;
      reg_q   <= w_reg;
      op_q    <= op_e'(w_rd);
      busy_q  <= 1'b1;
      valid_q <= 1'b0;
    end else if (done) begin
      busy_q <= 1'b0;
      if (op_q == OP_READ) begin
        data_q  <= rx_data;
        valid_q <= 1'b1;
      end
    end
  end

  assign status = {{(WORD_W-BUSY_BIT-1){1'b0}}, busy_q, valid_q, op_q,
                   reg_q, phy_q, data_q};

  a_r2_busy_on_accept: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !busy_q) |=> busy_q);
  a_r4_valid_cleared: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !busy_q) |=> !valid_q);
  a_r3_ignore_busy_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && busy_q) |=> ($stable(phy_q) && $stable(reg_q) && $stable(op_q)));
  a_r8_valid_after_read: assert property (@(posedge clk) disable iff (rst)
    (done && busy_q && op_q == OP_READ) |=> (valid_q && !busy_q));
  a_r11_write_no_valid: assert property (@(posedge clk) disable iff (rst)
    (done && busy_q && op_q == OP_WRITE) |=> !valid_q);
endmodule

// File: rtl/mgmt_frame_engine.sv
module mgmt_frame_engine
  import phy_mgmt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic                 start_rd,
  input  logic [FRAME_LEN-1:0] start_frame,
  input  logic                 fall_tick,
  input  logic                 rise_tick,
  input  logic                 mdio_i,
  output logic                 mdio_o,
  output logic                 mdio_oe,
  output logic                 done,
  output logic [DATA_W-1:0]    rx_data
);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(FRAME_LEN);
  localparam logic [CNT_W-1:0] REL_CNT  = CNT_W'(REL_IDX);
  localparam logic [CNT_W-1:0] DAT_CNT  = CNT_W'(DAT_IDX);

  logic                 run_q, rd_q;
  logic [CNT_W-1:0]     cnt_q;   // bits driven so far
  logic [FRAME_LEN-1:0] frm_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      rd_q    <= 1'b0;
      cnt_q   <= '0;
      frm_q   <= '0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
      done    <= 1'b0;
      rx_data <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        run_q <= 1'b1;
        rd_q  <= start_rd;
        cnt_q <= '0;
        frm_q <= start_frame;
      end else if (run_q && fall_tick) begin
        if (cnt_q == LAST_CNT) begin
          run_q   <= 1'b0;
          mdio_o  <= 1'b1;
          mdio_oe <= 1'b0;
          done    <= 1'b1;
        end else begin
          mdio_o  <= frm_q[FRAME_LEN-1];
          frm_q   <= {frm_q[FRAME_LEN-2:0], 1'b1};
          mdio_oe <= !(rd_q && cnt_q >= REL_CNT);
          cnt_q   <= cnt_q + 1'b1;
        end
      end else if (run_q && rise_tick && rd_q && cnt_q > DAT_CNT) begin
        rx_data <= {rx_data[DATA_W-2:0], mdio_i};
      end
    end
  end

  // R8: line released during the read tail
  a_r8_released_on_read: assert property (@(posedge clk) disable iff (rst)
    (run_q && rd_q && cnt_q > REL_CNT) |-> !mdio_oe);
  // R7: a write frame drives every bit once started
  a_r7_driven_on_write: assert property (@(posedge clk) disable iff (rst)
    (run_q && !rd_q && cnt_q != '0) |-> mdio_oe);
endmodule

// File: rtl/phy_mgmt_master.sv
module phy_mgmt_master
  import phy_mgmt_pkg::*;
#(
  parameter int HALF_DIV = 20
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cmd_wr,
  input  logic [31:0] cmd_wdata,
  output logic [31:0] cmd_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic                 fall_tick, rise_tick;
  logic                 start, start_rd, done, busy;
  logic [FRAME_LEN-1:0] start_frame;
  logic [DATA_W-1:0]    rx_data;

  mgmt_clk_div #(.HALF_DIV(HALF_DIV)) u_div (
    .clk(clk), .rst(rst), .mdc(mdc),
    .fall_tick(fall_tick), .rise_tick(rise_tick)
  );

  mgmt_cmd_reg u_cmd (
    .clk(clk), .rst(rst), .wr_en(cmd_wr), .wr_data(cmd_wdata),
    .done(done), .rx_data(rx_data), .start(start), .start_rd(start_rd),
    .start_frame(start_frame), .busy(busy), .status(cmd_rdata)
  );

  mgmt_frame_engine u_eng (
    .clk(clk), .rst(rst), .start(start), .start_rd(start_rd),
    .start_frame(start_frame), .fall_tick(fall_tick), .rise_tick(rise_tick),
    .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .done(done), .rx_data(rx_data)
  );

  a_r9_data_on_fall: assert property (@(posedge clk) disable iff (rst)
    !$stable(mdio_o) |-> $fell(mdc));
  a_r10_idle_released: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdio_oe);
endmodule

// File: tb/phy_mgmt_master_tb.sv
module phy_mgmt_master_tb;
  localparam int HD = 2;

  logic        clk = 1'b0, rst = 1'b1, cmd_wr = 1'b0, mdio_i = 1'b1;
  logic [31:0] cmd_wdata = '0;
  wire  [31:0] cmd_rdata;
  wire         mdc, mdio_o, mdio_oe;

  phy_mgmt_master #(.HALF_DIV(HD)) u_dut (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
    .cmd_rdata(cmd_rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i)
  );

  always #4 clk = ~clk;

  int n_cmp = 0, n_bad = 0, r9_bad = 0;
  longint cyc = 0;
  bit armed = 0;
  int cap_cnt = 0;
  logic [63:0] cap_bits, cap_oe;
  logic [15:0] phy_word = '0;
  logic prev_o = 1'b1, prev_mdc = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  // PHY model: record master bits on rising MDC, drive reply on falling MDC
  always @(posedge mdc) begin
    if (armed && cap_cnt < 64 && (cap_cnt > 0 || mdio_oe === 1'b1)) begin
      cap_bits[63-cap_cnt] = mdio_o;
      cap_oe[63-cap_cnt]   = mdio_oe;
      cap_cnt++;
    end
  end

  always @(negedge mdc) begin
    mdio_i = 1'b1;
    if (armed && cap_cnt == 47) mdio_i = 1'b0;
    else if (armed && cap_cnt >= 48 && cap_cnt < 64) mdio_i = phy_word[63-cap_cnt];
  end

  // R9 monitor: data output may move only when MDC falls
  always @(negedge clk) begin
    if (!rst && mdio_o !== prev_o && !(prev_mdc === 1'b1 && mdc === 1'b0)) r9_bad++;
    prev_o   = mdio_o;
    prev_mdc = mdc;
  end

  function automatic logic [31:0] mkcmd(input bit rd, input logic [4:0] p,
                                        input logic [4:0] r, input logic [15:0] d);
    return {5'b0, rd, r, p, d};
  endfunction

  function automatic logic [63:0] mkframe(input bit rd, input logic [4:0] p,
                                          input logic [4:0] r, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), p, r, 2'b10, d};
  endfunction

  task automatic issue(input logic [31:0] w);
    @(negedge clk);
    cmd_wdata = w;
    cmd_wr    = 1'b1;
    @(negedge clk);
    cmd_wr    = 1'b0;
  endtask

  task automatic wait_idle(output bit ok);
    ok = 0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (cmd_rdata[28] == 1'b0) begin ok = 1; break; end
    end
  endtask

  task automatic check_done(input bit rd, input logic [4:0] p, input logic [4:0] r,
                            input logic [15:0] d, input logic [15:0] pw);
    logic [63:0] ef;
    ef = mkframe(rd, p, r, d);
    chk(cap_cnt == 64, "R6 bit count", 64'(cap_cnt), 64'd64);
    chk(cap_bits[63:18] == ef[63:18], "R6 header", cap_bits, ef);
    chk(mdio_oe == 1'b0, "R10 enable idle", 64'(mdio_oe), 64'd0);
    if (!rd) begin
      chk(cap_bits[17:0] == ef[17:0], "R7 turnaround/data", cap_bits, ef);
      chk(cap_oe == '1, "R7 enable", cap_oe, '1);
      chk(cmd_rdata[27] == 1'b0, "R11 valid after write", 64'(cmd_rdata), 64'd0);
    end else begin
      chk(cap_oe == {{46{1'b1}}, 18'b0}, "R8 release", cap_oe, {{46{1'b1}}, 18'b0});
      chk(cmd_rdata[27] == 1'b1 && cmd_rdata[15:0] == pw, "R8 result",
          64'(cmd_rdata), 64'({16'h0800 | 16'(cmd_rdata[31:16]), pw}));
    end
  endtask

  task automatic run_frame(input bit rd, input logic [4:0] p, input logic [4:0] r,
                           input logic [15:0] d, input logic [15:0] pw);
    bit ok;
    phy_word = pw;
    cap_cnt  = 0;
    armed    = 1;
    issue(mkcmd(rd, p, r, d));
    chk(cmd_rdata[28] == 1'b1, "R2 busy set", 64'(cmd_rdata), 64'h1000_0000);
    chk(cmd_rdata[27] == 1'b0, "R4 valid cleared", 64'(cmd_rdata), 64'd0);
    chk(cmd_rdata[26:16] == {rd, r, p} && cmd_rdata[31:29] == 3'b0 &&
        (rd || cmd_rdata[15:0] == d), "R1 echo",
        64'(cmd_rdata), 64'(mkcmd(rd, p, r, d) | 32'h1000_0000));
    wait_idle(ok);
    armed = 0;
    chk(ok, "R2 busy clears", 64'(cmd_rdata), 64'd0);
    check_done(rd, p, r, d, pw);
  endtask

  initial begin
    longint t0, t1, t2;
    bit ok;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cmd_rdata == 32'd0, "R10 reset word", 64'(cmd_rdata), 64'd0);
    chk(mdio_oe == 1'b0, "R10 reset enable", 64'(mdio_oe), 64'd0);

    @(posedge mdc); t0 = cyc;
    @(negedge mdc); t1 = cyc;
    @(posedge mdc); t2 = cyc;
    chk(t1 - t0 == HD, "R5 high time", 64'(t1 - t0), 64'(HD));
    chk(t2 - t0 == 2 * HD, "R5 period", 64'(t2 - t0), 64'(2 * HD));

    // sweep every PHY address with a write then a read
    for (int p = 0; p < 32; p++) begin
      logic [4:0]  ra, rb;
      logic [15:0] wd, pw;
      ra = 5'((p * 7 + 3) % 32);
      rb = 5'(31 - p);
      wd = 16'(p * 16'h0813) ^ 16'hA5C3;
      pw = ~16'(p * 16'h1357);
      run_frame(1'b0, 5'(p), ra, wd, 16'h0);
      run_frame(1'b1, 5'(p), rb, 16'h0, pw);
    end
    run_frame(1'b1, 5'h1F, 5'h1F, 16'h0, 16'hFFFF);
    run_frame(1'b1, 5'h00, 5'h00, 16'h0, 16'h0000);
    run_frame(1'b0, 5'h1F, 5'h1F, 16'hFFFF, 16'h0);

    // R3: a command written during a frame is dropped
    phy_word = 16'hBEEF;
    cap_cnt  = 0;
    armed    = 1;
    issue(mkcmd(1'b1, 5'd9, 5'd4, 16'h0));
    repeat (40) @(negedge clk);
    issue(mkcmd(1'b0, 5'd22, 5'd17, 16'h1234));
    chk(cmd_rdata[28:16] == {1'b1, 1'b0, 1'b1, 5'd4, 5'd9}, "R3 echo kept",
        64'(cmd_rdata), 64'({1'b1, 1'b0, 1'b1, 5'd4, 5'd9, 16'h0}));
    wait_idle(ok);
    armed = 0;
    chk(ok, "R2 busy clears", 64'(cmd_rdata), 64'd0);
    check_done(1'b1, 5'd9, 5'd4, 16'h0, 16'hBEEF);
    repeat (300) @(negedge clk);
    chk(cmd_rdata[28] == 1'b0 && mdio_oe == 1'b0, "R3 no late frame",
        64'(cmd_rdata), 64'(32'h0800_BEEF | 32'(cmd_rdata[26:16]) << 16));

    chk(r9_bad == 0, "R9 output change timing", 64'(r9_bad), 64'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule